// File: doc/BRIEF.md
# Communication Cycle Timing Generator

This block keeps time for a periodic communication cycle. A predivider turns the system clock into a one-microsecond tick. A microsecond counter runs inside each cycle and restarts when the cycle ends. Software requests cycles in one of two ways: it writes a start command, or it enables sampling of an external cycle-clock pin on the rising or the falling edge. In both cases the first cycle begins after a programmable delay, counted in microseconds. One trigger launches a programmable number of back-to-back cycles. While a burst of cycles is still pending or running, further triggers have no effect.

During each cycle, equality compares against the microsecond counter place every output event:

- four time-interrupt pulses, one clock wide, for an interrupt controller;
- a control window output that opens at one compare time and closes at another;
- a burst of evenly spaced pulses, each one tick wide, on a second output.

A small word-addressed register port holds all parameters. The same port provides a snapshot of the live counter.

Top module: `cycle_timer`

## Requirements
- R1: The microsecond tick occurs once every PREDIV+1 clocks, where PREDIV is register 0, bits 4:0. The reset value of PREDIV is 19.
- R2: A cycle burst is triggered in either of two ways. The first is a write to register 2 with bit 0 set. The second is an edge on `cyc_clk_in` after its two-flop synchroniser, when CTRL (register 1) bit 0 is set. CTRL bit 1 selects the edge: 0 means rising, 1 means falling. `cyc_busy` rises one clock after the trigger. Counting starts on the (DELAY+1)-th tick after the trigger, where DELAY is register 3.
- R3: A trigger of either kind that arrives while `cyc_busy` is high is ignored. The pending or running burst is not changed by it.
- R4: The cycle length in microseconds is CT0 (register 4) or CT1 (register 5). CTRL bit 5 selects which one. The counter loads CNTINIT (register 13) at each cycle start and advances by one on every tick. On the tick at which it equals length−1, the cycle ends. A burst has CTRL[11:8] cycles, where the value 0 counts as 1. After the last cycle, `cyc_busy` falls.
- R5: `time_irq[i]` is a one-clock pulse. It appears one clock after a tick at which the running counter equals CMPi (registers 6 to 9).
- R6: When CTRL bit 2 is set, the control window is active. It becomes active on the tick at which the counter equals CMP0 and becomes inactive on the tick at which it equals CMP1. If both match on the same tick, the window becomes inactive. The window is forced inactive while idle. `ctl_clk_out` is the window level XOR CTRL bit 3.
- R7: Each cycle produces DCOUNT (register 12, bits 7:0) pulses on the divided-clock output. They occur at counter values DFIRST (register 10) plus k times DSPACE (register 11). Each pulse lasts exactly one tick. `div_clk_out` is the pulse level XOR CTRL bit 4. A pulse that falls on the last microsecond of a cycle is still emitted, and the next cycle receives a full new burst.
- R8: A write to register 2 with bit 1 set copies the counter value from before that edge into register 14, where it can be read back.
- R9: Registers read back with the written bits. CTRL reads back masked to 0x0F3F. Register 2 and unused addresses read 0. After reset, every register reads 0 except PREDIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| cyc_clk_in | input | 1 | External cycle clock (asynchronous) |
| time_irq | output | 4 | Time-interrupt pulses, one per compare |
| ctl_clk_out | output | 1 | Control window output |
| div_clk_out | output | 1 | Divided-clock pulse burst output |
| cyc_busy | output | 1 | High from trigger acceptance until the burst ends |

## Verification
The sharpest collision is a divided-clock pulse that falls on the last microsecond of a cycle. That pulse and the rearm of the pulse counter happen on the same clock edge. The bench provokes this case by setting DFIRST to the last count value. It then runs a three-cycle burst and expects exactly one pulse per cycle, with none lost at the wrap. A second case sets CMP0 equal to CMP1, so the window opens and closes on the same tick; it must stay inactive. A behavioural model in the bench judges every output on every clock.

// File: rtl/cyc_tmr_pkg.sv
package cyc_tmr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  localparam int N_CMP = 4;

  localparam logic [4:0] A_PREDIV = 5'd0;
  localparam logic [4:0] A_CTRL   = 5'd1;
  localparam logic [4:0] A_CMD    = 5'd2;
  localparam logic [4:0] A_DELAY  = 5'd3;
  localparam logic [4:0] A_CT0    = 5'd4;
  localparam logic [4:0] A_CT1    = 5'd5;
  localparam logic [4:0] A_CMP0   = 5'd6;
  localparam logic [4:0] A_DFIRST = 5'd10;
  localparam logic [4:0] A_DSPACE = 5'd11;
  localparam logic [4:0] A_DCOUNT = 5'd12;
  localparam logic [4:0] A_CINIT  = 5'd13;
  localparam logic [4:0] A_SNAP   = 5'd14;

  localparam int B_TRIG_EN   = 0;
  localparam int B_TRIG_FALL = 1;
  localparam int B_CTL_EN    = 2;
  localparam int B_CTL_INV   = 3;
  localparam int B_DIV_INV   = 4;
  localparam int B_BLK_SEL   = 5;
  localparam int B_NCYC_LSB  = 8;

endpackage

// File: rtl/ctg_tick.sv
module ctg_tick #(
  parameter int PW      = 5,
  parameter int PRE_RST = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] reload,
  output logic          tick
);
  logic [PW-1:0] pre_q;

  assign tick = (pre_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= PW'(PRE_RST);
    else        pre_q <= tick ? reload : pre_q - 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload != '0) |=> !tick); // R1

endmodule

// File: rtl/ctg_seq.sv
module ctg_seq
  import cyc_tmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          trig,
  input  logic [CW-1:0] start_dly,
  input  logic [CW-1:0] ctime,
  input  logic [CW-1:0] cnt_init,
  input  logic [NW-1:0] ncyc,
  output phase_t        phase,
  output logic [CW-1:0] cnt,
  output logic          run_tick,
  output logic          rearm
);
  logic [CW-1:0] dly_q;
  logic [NW-1:0] left_q;
  logic          delay_done;
  logic          at_end;

  function automatic logic [CW-1:0] last_value(input logic [CW-1:0] t);
    return t - 1'b1;
  endfunction

  function automatic logic [NW-1:0] launches(input logic [NW-1:0] n);
    return (n == '0) ? NW'(1) : n;
  endfunction

  assign run_tick   = tick && (phase == PH_RUN);
  assign delay_done = tick && (phase == PH_DELAY) && (dly_q == start_dly);
  assign at_end     = run_tick && (cnt == last_value(ctime));
  assign rearm      = delay_done || (at_end && left_q != NW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      dly_q  <= '0;
      left_q <= '0;
      cnt    <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (trig) begin
          phase  <= PH_DELAY;
          dly_q  <= '0;
          left_q <= launches(ncyc);
        end
        PH_DELAY: if (tick) begin
          if (dly_q == start_dly) begin
            phase <= PH_RUN;
            cnt   <= cnt_init;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        PH_RUN: if (tick) begin
          if (cnt == last_value(ctime)) begin
            cnt <= cnt_init;
            if (left_q == NW'(1)) phase <= PH_IDLE;
            else                  left_q <= left_q - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && trig && !tick) |=> (phase == $past(phase))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && !tick) |=> $stable(cnt)); // R4
  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    delay_done |=> (phase == PH_RUN && cnt == $past(cnt_init))); // R2

endmodule

// File: rtl/ctg_events.sv
module ctg_events
  import cyc_tmr_pkg::*;
#(
  parameter int CW  = 16,
  parameter int DCW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      run_tick,
  input  logic                      idle,
  input  logic                      rearm,
  input  logic [CW-1:0]             cnt,
  input  logic [N_CMP-1:0][CW-1:0]  cmp,
  input  logic [CW-1:0]             div_first,
  input  logic [CW-1:0]             div_space,
  input  logic [DCW-1:0]            div_count,
  output logic [N_CMP-1:0]          irq,
  output logic                      ctl_act,
  output logic                      div_act
);
  logic [N_CMP-1:0] hit;
  logic [DCW-1:0]   dleft_q;
  logic [CW-1:0]    dnext_q;
  logic             fire;

  function automatic logic [CW-1:0] next_slot(input logic [CW-1:0] at,
                                              input logic [CW-1:0] gap);
    return at + gap;
  endfunction

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign hit[g] = run_tick && (cnt == cmp[g]);
  end

  assign fire = run_tick && (dleft_q != '0) && (cnt == dnext_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= '0;
      ctl_act <= 1'b0;
      div_act <= 1'b0;
      dleft_q <= '0;
      dnext_q <= '0;
    end else begin
      irq <= hit;
      if (idle)        ctl_act <= 1'b0;
      else if (hit[1]) ctl_act <= 1'b0;
      else if (hit[0]) ctl_act <= 1'b1;
      if (tick) div_act <= fire;
      if (rearm) begin
        dleft_q <= div_count;
        dnext_q <= div_first;
      end else if (fire) begin
        dleft_q <= dleft_q - 1'b1;
        dnext_q <= next_slot(dnext_q, div_space);
      end
    end
  end

  AST_DIV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (div_act && !tick) |=> div_act); // R7
  AST_CTL_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !ctl_act); // R6
  AST_IRQ_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> $past(run_tick)); // R5

endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import cyc_tmr_pkg::*;
#(
  parameter int AW      = 5,
  parameter int CW      = 16,
  parameter int PW      = 5,
  parameter int PRE_RST = 19,
  parameter int NW      = 4,
  parameter int DCW     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [CW-1:0]    reg_wdata,
  output logic [CW-1:0]    reg_rdata,
  input  logic             cyc_clk_in,
  output logic [N_CMP-1:0] time_irq,
  output logic             ctl_clk_out,
  output logic             div_clk_out,
  output logic             cyc_busy
);
  logic [PW-1:0]            prediv_q;
  logic                     trig_en_q, trig_fall_q, ctl_en_q, ctl_inv_q, div_inv_q, blk_sel_q;
  logic [NW-1:0]            ncyc_q;
  logic [CW-1:0]            dly_q, ct0_q, ct1_q, dfirst_q, dspace_q, cinit_q, snap_q;
  logic [DCW-1:0]           dcount_q;
  logic [N_CMP-1:0][CW-1:0] cmp_q;
  logic [2:0]               sync_q;

  logic   tick, run_tick, rearm, ctl_act, div_act;
  logic   cmd_wr, sw_start, snap_req, pin_edge, trig;
  phase_t phase;
  logic [CW-1:0] cnt;

  assign cmd_wr   = reg_we && (reg_addr == A_CMD);
  assign sw_start = cmd_wr && reg_wdata[0];
  assign snap_req = cmd_wr && reg_wdata[1];
  assign pin_edge = trig_fall_q ? (!sync_q[1] && sync_q[2]) : (sync_q[1] && !sync_q[2]);
  assign trig     = sw_start || (trig_en_q && pin_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prediv_q <= PW'(PRE_RST);
      {trig_en_q, trig_fall_q, ctl_en_q, ctl_inv_q, div_inv_q, blk_sel_q} <= '0;
      ncyc_q   <= '0;
      dly_q    <= '0; ct0_q <= '0; ct1_q <= '0;
      dfirst_q <= '0; dspace_q <= '0; cinit_q <= '0; snap_q <= '0;
      dcount_q <= '0;
      cmp_q    <= '0;
      sync_q   <= '0;
    end else begin
      sync_q <= {sync_q[1:0], cyc_clk_in};
      if (reg_we) begin
        unique case (reg_addr)
          A_PREDIV: prediv_q <= reg_wdata[PW-1:0];
          A_CTRL: begin
            trig_en_q   <= reg_wdata[B_TRIG_EN];
            trig_fall_q <= reg_wdata[B_TRIG_FALL];
            ctl_en_q    <= reg_wdata[B_CTL_EN];
            ctl_inv_q   <= reg_wdata[B_CTL_INV];
            div_inv_q   <= reg_wdata[B_DIV_INV];
            blk_sel_q   <= reg_wdata[B_BLK_SEL];
            ncyc_q      <= reg_wdata[B_NCYC_LSB +: NW];
          end
          A_DELAY:  dly_q    <= reg_wdata;
          A_CT0:    ct0_q    <= reg_wdata;
          A_CT1:    ct1_q    <= reg_wdata;
          A_DFIRST: dfirst_q <= reg_wdata;
          A_DSPACE: dspace_q <= reg_wdata;
          A_DCOUNT: dcount_q <= reg_wdata[DCW-1:0];
          A_CINIT:  cinit_q  <= reg_wdata;
          default: ;
        endcase
        for (int i = 0; i < N_CMP; i++)
          if (int'(reg_addr) == int'(A_CMP0) + i) cmp_q[i] <= reg_wdata;
      end
      if (snap_req) snap_q <= cnt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_PREDIV: reg_rdata[PW-1:0] = prediv_q;
      A_CTRL: begin
        reg_rdata[B_TRIG_EN]          = trig_en_q;
        reg_rdata[B_TRIG_FALL]        = trig_fall_q;
        reg_rdata[B_CTL_EN]           = ctl_en_q;
        reg_rdata[B_CTL_INV]          = ctl_inv_q;
        reg_rdata[B_DIV_INV]          = div_inv_q;
        reg_rdata[B_BLK_SEL]          = blk_sel_q;
        reg_rdata[B_NCYC_LSB +: NW]   = ncyc_q;
      end
      A_DELAY:  reg_rdata = dly_q;
      A_CT0:    reg_rdata = ct0_q;
      A_CT1:    reg_rdata = ct1_q;
      A_DFIRST: reg_rdata = dfirst_q;
      A_DSPACE: reg_rdata = dspace_q;
      A_DCOUNT: reg_rdata[DCW-1:0] = dcount_q;
      A_CINIT:  reg_rdata = cinit_q;
      A_SNAP:   reg_rdata = snap_q;
      default: ;
    endcase
    for (int i = 0; i < N_CMP; i++)
      if (int'(reg_addr) == int'(A_CMP0) + i) reg_rdata = cmp_q[i];
  end

  ctg_tick #(.PW(PW), .PRE_RST(PRE_RST)) u_tick (
    .clk(clk), .rst_n(rst_n), .reload(prediv_q), .tick(tick)
  );

  ctg_seq #(.CW(CW), .NW(NW)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig),
    .start_dly(dly_q), .ctime(blk_sel_q ? ct1_q : ct0_q), .cnt_init(cinit_q),
    .ncyc(ncyc_q), .phase(phase), .cnt(cnt), .run_tick(run_tick), .rearm(rearm)
  );

  ctg_events #(.CW(CW), .DCW(DCW)) u_evt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_tick(run_tick),
    .idle(phase == PH_IDLE), .rearm(rearm), .cnt(cnt), .cmp(cmp_q),
    .div_first(dfirst_q), .div_space(dspace_q), .div_count(dcount_q),
    .irq(time_irq), .ctl_act(ctl_act), .div_act(div_act)
  );

  assign ctl_clk_out = (ctl_en_q && ctl_act) ^ ctl_inv_q;
  assign div_clk_out = div_act ^ div_inv_q;
  assign cyc_busy    = (phase != PH_IDLE);

  AST_BUSY_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_busy && trig) |=> cyc_busy); // R2
  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (snap_q == $past(cnt))); // R8

endmodule

// File: tb/tb_cycle_timer.sv
module tb_cycle_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        cyc_clk_in = 1'b0;
  logic [15:0] reg_rdata;
  logic [3:0]  time_irq;
  logic        ctl_clk_out, div_clk_out, cyc_busy;

  always #5 clk = ~clk;

  cycle_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_clk_in(cyc_clk_in),
    .time_irq(time_irq), .ctl_clk_out(ctl_clk_out), .div_clk_out(div_clk_out),
    .cyc_busy(cyc_busy)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  int mr[16];
  int m_pre, m_phase, m_dly, m_left, m_cnt, m_dleft, m_dnext, m_snap;
  bit m_irq[4];
  bit m_ctl, m_div, m_s1, m_s2, m_s3;

  function automatic bit bt(int v, int k); return ((v >> k) & 1) == 1; endfunction

  function automatic int exp_rd(int a);
    if (a == 2 || a == 15) return 0;
    if (a == 14) return m_snap;
    return mr[a];
  endfunction

  task automatic fail(string tag, int act, int exp);
    miscompares++;
    $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mr[i]) mr[i] = 0;
      mr[0] = 19; m_pre = 19;
      m_phase = 0; m_dly = 0; m_left = 0; m_cnt = 0; m_dleft = 0; m_dnext = 0; m_snap = 0;
      foreach (m_irq[i]) m_irq[i] = 0;
      m_ctl = 0; m_div = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit tk, rise, fall, trig, rt, fire, rearm;
      int ct, old_cnt;
      tk = (m_pre == 0);
      m_pre = tk ? mr[0] : m_pre - 1;                             // R1
      rise = m_s2 && !m_s3; fall = !m_s2 && m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cyc_clk_in;
      trig = (reg_we && reg_addr == 2 && reg_wdata[0]) ||
             (bt(mr[1], 0) && (bt(mr[1], 1) ? fall : rise));      // R2
      rt = tk && m_phase == 2;
      for (int i = 0; i < 4; i++) m_irq[i] = rt && (m_cnt == mr[6+i]);  // R5
      if (m_phase == 0) m_ctl = 0;
      else if (rt && m_cnt == mr[7]) m_ctl = 0;
      else if (rt && m_cnt == mr[6]) m_ctl = 1;                   // R6
      fire = rt && m_dleft != 0 && m_cnt == m_dnext;
      if (tk) m_div = fire;
      ct = bt(mr[1], 5) ? mr[5] : mr[4];
      old_cnt = m_cnt;
      rearm = 0;
      if (m_phase == 0) begin
        if (trig) begin
          m_phase = 1; m_dly = 0;
          m_left = (mr[1] >> 8) & 15; if (m_left == 0) m_left = 1;
        end
      end else if (m_phase == 1) begin
        if (tk) begin
          if (m_dly == mr[3]) begin m_phase = 2; m_cnt = mr[13]; rearm = 1; end
          else m_dly++;
        end
      end else if (tk) begin
        if (m_cnt == ((ct - 1) & 16'hFFFF)) begin                 // R4
          m_cnt = mr[13];
          if (m_left == 1) m_phase = 0;
          else begin m_left--; rearm = 1; end
        end else m_cnt = (m_cnt + 1) & 16'hFFFF;
      end
      if (rearm) begin m_dleft = mr[12]; m_dnext = mr[10]; end      // R7
      else if (fire) begin m_dleft--; m_dnext = (m_dnext + mr[11]) & 16'hFFFF; end
      if (reg_we && reg_addr == 2 && reg_wdata[1]) m_snap = old_cnt;  // R8
      if (reg_we && reg_addr != 2 && reg_addr < 14) begin
        int v;
        v = int'(reg_wdata);
        if (reg_addr == 0) v &= 31;
        if (reg_addr == 1) v &= 16'h0F3F;
        if (reg_addr == 12) v &= 255;
        mr[reg_addr] = v;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ec;
      vectors++;
      for (int i = 0; i < 4; i++)
        if (time_irq[i] !== m_irq[i]) fail($sformatf("R5 time_irq[%0d]", i), time_irq[i], m_irq[i]);
      ec = (bt(mr[1], 2) && m_ctl) ^ bt(mr[1], 3);
      if (ctl_clk_out !== ec) fail("R6 ctl_clk_out", ctl_clk_out, ec);
      ec = m_div ^ bt(mr[1], 4);
      if (div_clk_out !== ec) fail("R7 div_clk_out", div_clk_out, ec);
      ec = (m_phase != 0);
      if (cyc_busy !== ec) fail("R2 R3 R4 cyc_busy", cyc_busy, ec);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: got %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input int a, input string tag);
    @(negedge clk);
    reg_addr = 5'(a);
    #1;
    vectors++;
    if (int'(reg_rdata) !== exp_rd(a)) fail(tag, reg_rdata, exp_rd(a));
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && cyc_busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd_check(0, "R9 reset PREDIV");
    rd_check(1, "R9 reset CTRL");
    rd_check(14, "R9 reset SNAP");

    // default predivider, short single cycle, R1
    wr(4, 4); wr(6, 1); wr(7, 3); wr(8, 0); wr(9, 2);
    wr(1, 16'h0104);
    wr(2, 1);
    wait_idle();
    repeat (50) @(negedge clk);

    // two-cycle burst, retrigger ignored, snapshot
    wr(0, 3); wr(4, 20); wr(5, 12);
    wr(6, 2); wr(7, 5); wr(8, 9); wr(9, 19);
    wr(10, 3); wr(11, 4); wr(12, 4); wr(3, 2);
    wr(1, 16'h0204);
    rd_check(1, "R9 CTRL readback");
    rd_check(12, "R9 DCOUNT readback");
    wr(2, 1);
    repeat (30) @(negedge clk);
    wr(2, 1);                       // R3 retrigger while busy
    repeat (40) @(negedge clk);
    wr(2, 2);                       // R8 snapshot
    rd_check(14, "R8 snapshot");
    rd_check(2, "R9 command reads zero");
    wait_idle();
    repeat (20) @(negedge clk);

    // rising pin trigger, CT1, inverted outputs, window open/close same tick,
    // divided pulse on the last microsecond (R7 collision)
    wr(6, 4); wr(7, 4);
    wr(10, 11); wr(11, 100); wr(12, 1); wr(3, 0);
    wr(1, 16'h033D);
    @(negedge clk); cyc_clk_in = 1'b1;
    repeat (40) @(negedge clk); cyc_clk_in = 1'b0;
    repeat (10) @(negedge clk); cyc_clk_in = 1'b1;   // R3 pin edge while busy
    wait_idle();
    repeat (20) @(negedge clk);

    // falling pin trigger with a start value, R4
    wr(13, 5); wr(10, 5); wr(11, 3); wr(12, 5);
    wr(6, 6); wr(7, 16);
    wr(1, 16'h0107);
    @(negedge clk); cyc_clk_in = 1'b0;
    repeat (20) @(negedge clk);
    wait_idle();
    repeat (10) @(negedge clk); cyc_clk_in = 1'b1;   // R2 rising edge ignored in falling mode
    repeat (100) @(negedge clk);
    rd_check(13, "R9 CNTINIT readback");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule